// File: doc/BRIEF.md
# Pulse-Stepped Synaptic Weight Cell

This block stands in, in fixed point, for one non-volatile analog weight cell of an adaptive network. The cell keeps a signed charge count, the digital stand-in for stored charge, and presents a weight equal to a per-cell offset plus a per-cell slope times that count. Because the slope and offset are inputs, two instances can model two cells from different process corners. Given the same pulse history, the two cells then produce different weights.

The weight is never written directly. A learning engine asks for a number of pulses in one direction, either strengthen or weaken, using a valid/ready handshake. The cell applies the pulses one per clock, moving the count by one step each time. A pulse that would carry the count past its configured floor or ceiling is refused, and the rest of that request is dropped. A sticky flag then records that the cell ran into a limit.

Top module: `pulse_weight_cell`

## Requirements
- R1: While reset is low, the count loads `cfg_cnt_init`, `weight_valid` is 0, `sat_flag` is 0 and `upd_ready` is 1. On the first rising edge with reset high, `weight_valid` goes to 1 and `weight` shows the value for the initial count.
- R2: `weight` is registered. It equals `cfg_offset + ((cfg_slope * count) >>> FRAC_W)`, with an arithmetic (floor) shift and FRAC_W = 2 by default. It reflects the count and configuration of the previous clock, so it settles one cycle after they change.
- R3: A request accepted with `upd_dec` = 0 and N pulses raises the count by exactly N. `upd_ready` is low for exactly N cycles after the accepting edge when no limit is reached.
- R4: A request accepted with `upd_dec` = 1 and N pulses lowers the count by exactly N, at the same rate of one pulse per clock.
- R5: The count never goes below `cfg_cnt_min` or above `cfg_cnt_max`. A request that crosses a limit is applied up to the limit. It then ends one cycle later, so `upd_ready` is low for (distance to limit + 1) cycles.
- R6: `sat_flag` is set when a pulse is refused at a limit. It stays set through later requests until reset.
- R7: A request of zero pulses is accepted without effect: `upd_ready` stays 1 and the weight does not change.
- R8: When the weight value falls outside the signed WEIGHT_W range, it saturates to +32767 or -32768 with the default width of 16.
- R9: The slope scales the weight change per pulse. A slope change while idle takes effect on `weight` one cycle later, and the count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slope | input | SLOPE_W | Signed per-cell gain, in units of 2^-FRAC_W |
| cfg_offset | input | WEIGHT_W | Signed weight at zero count |
| cfg_cnt_min | input | CNT_W | Signed lower count limit |
| cfg_cnt_max | input | CNT_W | Signed upper count limit |
| cfg_cnt_init | input | CNT_W | Signed count loaded during reset |
| upd_valid | input | 1 | Update request present |
| upd_ready | output | 1 | Cell idle and able to accept a request |
| upd_pulses | input | PULSE_W | Number of pulses requested |
| upd_dec | input | 1 | 1 weakens (count down), 0 strengthens (count up) |
| weight | output | WEIGHT_W | Signed weight value |
| weight_valid | output | 1 | Weight holds a value computed after reset |
| sat_flag | output | 1 | Sticky flag: a pulse was refused at a limit |

## Verification
The count is not visible at the ports, so an error in it shows up in `weight` one cycle after the count goes wrong, scaled by the slope. With a slope of one whole unit, each lost or extra pulse shifts the weight by exactly one. An error in the remaining-pulse counter shows up instead as a wrong number of cycles with `upd_ready` low. It can also show up as a count that stops short of, or runs past, a limit, together with a missing or early `sat_flag`.

// File: rtl/pulse_weight_cell.sv
module pulse_weight_cell #(
  parameter int CNT_W    = 10,
  parameter int SLOPE_W  = 8,
  parameter int WEIGHT_W = 16,
  parameter int FRAC_W   = 2,
  parameter int PULSE_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SLOPE_W-1:0]  cfg_slope,
  input  logic signed [WEIGHT_W-1:0] cfg_offset,
  input  logic signed [CNT_W-1:0]    cfg_cnt_min,
  input  logic signed [CNT_W-1:0]    cfg_cnt_max,
  input  logic signed [CNT_W-1:0]    cfg_cnt_init,
  input  logic                       upd_valid,
  output logic                       upd_ready,
  input  logic [PULSE_W-1:0]         upd_pulses,
  input  logic                       upd_dec,
  output logic signed [WEIGHT_W-1:0] weight,
  output logic                       weight_valid,
  output logic                       sat_flag
);
  localparam int PROD_W = SLOPE_W + CNT_W;
  localparam int SUM_W  = ((PROD_W > WEIGHT_W) ? PROD_W : WEIGHT_W) + 1;
  localparam logic signed [SUM_W-1:0] W_MAX = SUM_W'((64'd1 << (WEIGHT_W - 1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] W_MIN = ~W_MAX;

  logic signed [CNT_W-1:0]    cnt_q;
  logic [PULSE_W-1:0]         left_q;
  logic                       dec_q;
  logic                       sat_q;
  logic signed [WEIGHT_W-1:0] w_q;
  logic                       wv_q;

  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   scaled;
  logic signed [SUM_W-1:0]    off_x;
  logic signed [SUM_W-1:0]    scl_x;
  logic signed [SUM_W-1:0]    sum;
  logic signed [WEIGHT_W-1:0] w_next;
  logic                       at_lim;

  assign prod   = PROD_W'(cfg_slope) * PROD_W'(cnt_q);
  assign scaled = prod >>> FRAC_W;
  assign off_x  = SUM_W'(cfg_offset);
  assign scl_x  = SUM_W'(scaled);
  assign sum    = off_x + scl_x;
  assign w_next = (sum > W_MAX) ? W_MAX[WEIGHT_W-1:0] :
                  (sum < W_MIN) ? W_MIN[WEIGHT_W-1:0] : sum[WEIGHT_W-1:0];
  assign at_lim = dec_q ? (cnt_q <= cfg_cnt_min) : (cnt_q >= cfg_cnt_max);

  assign upd_ready    = (left_q == '0);
  assign weight       = w_q;
  assign weight_valid = wv_q;
  assign sat_flag     = sat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= cfg_cnt_init;
      left_q <= '0;
      dec_q  <= 1'b0;
      sat_q  <= 1'b0;
      w_q    <= '0;
      wv_q   <= 1'b0;
    end else begin
      wv_q <= 1'b1;
      w_q  <= w_next;
      if (upd_valid && upd_ready) begin
        left_q <= upd_pulses;
        dec_q  <= upd_dec;
      end else if (left_q != '0) begin
        if (at_lim) begin
          sat_q  <= 1'b1;
          left_q <= '0;
        end else begin
          cnt_q  <= dec_q ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
          left_q <= left_q - PULSE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pulse_weight_cell_chk.sv
module pulse_weight_cell_chk #(
  parameter int CNT_W   = 10,
  parameter int PULSE_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    upd_valid,
  input logic                    upd_ready,
  input logic [PULSE_W-1:0]      upd_pulses,
  input logic                    weight_valid,
  input logic                    sat_flag,
  input logic signed [CNT_W-1:0] cnt_q,
  input logic signed [CNT_W-1:0] cfg_cnt_min,
  input logic signed [CNT_W-1:0] cfg_cnt_max
);
  p_valid_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> weight_valid);

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_pulses != '0) |=> !upd_ready);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_count_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= cfg_cnt_min) && (cnt_q <= cfg_cnt_max));

  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);

  p_idle_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ready && !upd_valid) |=> upd_ready);
endmodule

bind pulse_weight_cell pulse_weight_cell_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .upd_pulses(upd_pulses), .weight_valid(weight_valid), .sat_flag(sat_flag),
  .cnt_q(cnt_q), .cfg_cnt_min(cfg_cnt_min), .cfg_cnt_max(cfg_cnt_max)
);

// File: tb/pulse_weight_cell_tb.sv
module pulse_weight_cell_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [7:0]  cfg_slope = 8'sd4;
  logic signed [15:0] cfg_offset = '0;
  logic signed [9:0]  cfg_cnt_min = -10'sd10;
  logic signed [9:0]  cfg_cnt_max = 10'sd10;
  logic signed [9:0]  cfg_cnt_init = '0;
  logic              upd_valid = 1'b0;
  logic              upd_ready;
  logic [5:0]        upd_pulses = '0;
  logic              upd_dec = 1'b0;
  logic signed [15:0] weight;
  logic              weight_valid;
  logic              sat_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_weight_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_slope(cfg_slope), .cfg_offset(cfg_offset),
    .cfg_cnt_min(cfg_cnt_min), .cfg_cnt_max(cfg_cnt_max), .cfg_cnt_init(cfg_cnt_init),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pulses(upd_pulses),
    .upd_dec(upd_dec), .weight(weight), .weight_valid(weight_valid), .sat_flag(sat_flag)
  );

  function automatic int model_w(input int off, input int sl, input int c);
    int s;
    s = off + ((sl * c) >>> 2);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mn, input int mx, input int init, input int sl, input int off);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_cnt_min  = 10'(mn);
    cfg_cnt_max  = 10'(mx);
    cfg_cnt_init = 10'(init);
    cfg_slope    = 8'(sl);
    cfg_offset   = 16'(off);
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(weight_valid), 0);
    chk("R1 ready in reset", int'(upd_ready), 1);
    chk("R1 sat clear in reset", int'(sat_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(weight_valid), 1);
    chk("R1 weight of init count", int'(weight), model_w(off, sl, init));
  endtask

  task automatic req(input int n, input bit dec, output int busy);
    upd_valid  = 1'b1;
    upd_pulses = 6'(n);
    upd_dec    = dec;
    @(negedge clk);
    upd_valid = 1'b0;
    busy = 0;
    while (!upd_ready) begin
      busy++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_inc_dec_r3_r4();
    int b;
    do_reset(-20, 20, 7, 4, 10);
    req(9, 1'b0, b);
    chk("R3 busy cycles up", b, 9);
    chk("R3 weight after up", int'(weight), 26);
    req(12, 1'b1, b);
    chk("R4 busy cycles down", b, 12);
    chk("R4 weight after down", int'(weight), 14);
  endtask

  task automatic t_zero_r7();
    int b;
    req(0, 1'b0, b);
    chk("R7 zero request busy", b, 0);
    chk("R7 zero request ready", int'(upd_ready), 1);
    chk("R7 zero request weight", int'(weight), 14);
  endtask

  task automatic t_sat_r5_r6();
    int b;
    do_reset(-5, 5, 0, 4, 100);
    req(5, 1'b0, b);
    chk("R5 exact reach busy", b, 5);
    chk("R5 exact reach weight", int'(weight), 105);
    chk("R6 no flag at exact reach", int'(sat_flag), 0);
    req(3, 1'b0, b);
    chk("R5 refused at max busy", b, 1);
    chk("R5 held at max", int'(weight), 105);
    chk("R6 flag set", int'(sat_flag), 1);
    req(2, 1'b1, b);
    chk("R6 flag sticky", int'(sat_flag), 1);
    chk("R4 down after limit", int'(weight), 103);
    do_reset(-5, 5, 0, 4, 100);
    req(20, 1'b1, b);
    chk("R5 partial at min busy", b, 6);
    chk("R5 held at min", int'(weight), 95);
    chk("R6 flag at min", int'(sat_flag), 1);
  endtask

  task automatic t_slope_r9();
    int b;
    do_reset(-50, 50, 0, 8, 0);
    req(3, 1'b0, b);
    chk("R9 slope 8 three pulses", int'(weight), 6);
    cfg_slope = 8'sd3;
    @(negedge clk);
    chk("R9 slope change next cycle", int'(weight), model_w(0, 3, 3));
    req(6, 1'b1, b);
    chk("R2 floor of negative product", int'(weight), model_w(0, 3, -3));
    cfg_slope = 8'sd12;
    @(negedge clk);
    chk("R9 count kept over slope change", int'(weight), -9);
  endtask

  task automatic t_clip_r8();
    do_reset(-200, 200, 100, 127, 29000);
    chk("R2 large in range", int'(weight), 32175);
    do_reset(-200, 200, 100, 127, 32000);
    chk("R8 clip high", int'(weight), 32767);
    do_reset(-200, 200, -100, 127, -32000);
    chk("R8 clip low", int'(weight), -32768);
  endtask

  initial begin
    t_inc_dec_r3_r4();
    t_zero_r7();
    t_sat_r5_r6();
    t_slope_r9();
    t_clip_r8();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule